// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block holds two identical 32-bit up-counters that advance once per core clock. Each counter runs from whatever value software last wrote into it up to a programmable limit; in the cycle it sits at the limit it returns to zero on the next edge and keeps going. Left at reset, or with the counter written to zero and the limit set to all ones, a channel is a plain free-running 32-bit cycle counter.

Each channel has an interrupt-enable bit and a sticky pending bit. With the enable set, arriving at the limit sets the pending bit, and the channel's interrupt line follows pending AND enable as a level. The pending bit stays set, and no further event is raised, until software writes the channel's control register. That write clears pending and rearms the channel. Writing control once after each event gives periodic interrupts. Writing it once only gives a single event. The counter itself never stops.

Software reaches the registers through a flat write port and a combinational read port that share one address. The read port returns the live count without disturbing it.

Top module: `lcmp_timer`

## Requirements
- R1: When a channel's count differs from its limit and no count write is made, the count rises by exactly one on every clock edge.
- R2: After reset every count reads 0, every limit reads 0xFFFFFFFF, every control register reads 0 and every interrupt output is low.
- R3: When the count equals the limit, the next edge loads zero, and counting continues from there with no pause.
- R4: Arriving at the limit while the enable bit (control bit 0) is 1 sets the pending bit (control bit 1) on that same edge. With the enable bit at 0 the pending bit is not set.
- R5: A count write takes effect on the next edge and takes precedence over both increment and wrap. Counting resumes upward from the written value.
- R6: Once set, the pending bit stays at 1 through any number of further limit arrivals until a control write. A control write clears it, unless the limit is reached on that same edge with the newly written enable at 1, in which case it is set.
- R7: Each interrupt output is the level pending AND enable of its channel.
- R8: The address is {channel index, register select[1:0]}, with select 0 = count, 1 = limit, 2 = control (bit 0 enable writable, bit 1 pending read-only, other bits read 0). Select 3 reads 0 and writes to it change nothing. Reads are combinational and leave the counter unaffected.
- R9: A write to one channel leaves the other channel's count progression, limit and control untouched.
- R10: With limit 0xFFFFFFFF a channel steps from 0xFFFFFFFF to 0 and keeps counting, so it acts as a free-running 32-bit counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; counters step on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | {channel index, register select} for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for addr |
| irq | output | 2 | Per-channel interrupt level |

## Verification
The two things that can land on the same edge are an arrival at the limit and a software write: either a control write (rearm) or a count write. The bench counts cycles from a known count so that a rearm write, or a count write, is presented exactly while the count equals the limit. It then judges that the interrupt comes out asserted rather than cleared, and that the written count replaces the wrap to zero. One such collision is also made while the enable bit is being switched on, and the bench expects an event from that write.

// File: rtl/lcmp_tmr_pkg.sv
package lcmp_tmr_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RSVD  = 2'd3
  } regSel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PEND_BIT = 1;

  typedef struct packed {
    logic loadCount;
    logic loadLimit;
    logic writeCtrl;
  } tmrStrobe_t;

endpackage

// File: rtl/lcmp_tmr_datapath.sv
module lcmp_tmr_datapath
  import lcmp_tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countNext;

  assign hit = (count == limit);

  always_comb begin
    if (strobe.loadCount) begin
      countNext = wrData;
    end else if (hit) begin
      countNext = '0;
    end else begin
      countNext = count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      limit <= '1;
    end else begin
      count <= countNext;
      if (strobe.loadLimit) begin
        limit <= wrData;
      end
    end
  end

endmodule

// File: rtl/lcmp_tmr_ctrl.sv
module lcmp_tmr_ctrl
  import lcmp_tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int IDX_W      = 1,
  parameter int ADDR_W     = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  enBit,
  input  logic [NUM_TIMERS-1:0] hitVec,
  output tmrStrobe_t [NUM_TIMERS-1:0] strobeVec,
  output logic [NUM_TIMERS-1:0] enVec,
  output logic [NUM_TIMERS-1:0] pendVec,
  output logic [NUM_TIMERS-1:0] irq
);

  logic [IDX_W-1:0] wrIdx;
  regSel_e          wrSel;

  assign wrIdx = addr[ADDR_W-1:2];
  assign wrSel = regSel_e'(addr[1:0]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    logic chanSel;
    logic enNext;
    logic pendNext;

    assign chanSel = wrEn && (wrIdx == IDX_W'(i));

    always_comb begin
      strobeVec[i].loadCount = chanSel && (wrSel == SEL_COUNT);
      strobeVec[i].loadLimit = chanSel && (wrSel == SEL_LIMIT);
      strobeVec[i].writeCtrl = chanSel && (wrSel == SEL_CTRL);
    end

    always_comb begin
      if (strobeVec[i].writeCtrl) begin
        enNext   = enBit;
        pendNext = 1'b0;
      end else begin
        enNext   = enVec[i];
        pendNext = pendVec[i];
      end
      if (hitVec[i] && enNext) begin
        pendNext = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enVec[i]   <= 1'b0;
        pendVec[i] <= 1'b0;
      end else begin
        enVec[i]   <= enNext;
        pendVec[i] <= pendNext;
      end
    end

    assign irq[i] = pendVec[i] & enVec[i];
  end

endmodule

// File: rtl/lcmp_timer.sv
module lcmp_timer
  import lcmp_tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int CNT_W      = 32,
  localparam int IDX_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W    = IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  output logic [NUM_TIMERS-1:0] irq
);

  tmrStrobe_t [NUM_TIMERS-1:0]             strobeVec;
  logic       [NUM_TIMERS-1:0][CNT_W-1:0]  cntVec;
  logic       [NUM_TIMERS-1:0][CNT_W-1:0]  limVec;
  logic       [NUM_TIMERS-1:0]             hitVec;
  logic       [NUM_TIMERS-1:0]             enVec;
  logic       [NUM_TIMERS-1:0]             pendVec;

  lcmp_tmr_ctrl #(
    .NUM_TIMERS(NUM_TIMERS),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .enBit    (wrData[CTRL_EN_BIT]),
    .hitVec   (hitVec),
    .strobeVec(strobeVec),
    .enVec    (enVec),
    .pendVec  (pendVec),
    .irq      (irq)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dp
    lcmp_tmr_datapath #(
      .CNT_W(CNT_W)
    ) dp_i (
      .clk   (clk),
      .rstN  (rstN),
      .strobe(strobeVec[i]),
      .wrData(wrData),
      .count (cntVec[i]),
      .limit (limVec[i]),
      .hit   (hitVec[i])
    );
  end

  logic [IDX_W-1:0] rdIdx;
  regSel_e          rdSel;

  assign rdIdx = addr[ADDR_W-1:2];
  assign rdSel = regSel_e'(addr[1:0]);

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rdIdx == IDX_W'(i)) begin
        unique case (rdSel)
          SEL_COUNT: rdData = cntVec[i];
          SEL_LIMIT: rdData = limVec[i];
          SEL_CTRL: begin
            rdData[CTRL_EN_BIT]   = enVec[i];
            rdData[CTRL_PEND_BIT] = pendVec[i];
          end
          default:   rdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/lcmp_timer_chk.sv
module lcmp_timer_chk
  import lcmp_tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int CNT_W      = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [CNT_W-1:0]                 wrData,
  input tmrStrobe_t [NUM_TIMERS-1:0]      strobeVec,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0] limVec,
  input logic [NUM_TIMERS-1:0]            hitVec,
  input logic [NUM_TIMERS-1:0]            enVec,
  input logic [NUM_TIMERS-1:0]            pendVec,
  input logic [NUM_TIMERS-1:0]            irq
);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (!strobeVec[i].loadCount && (cntVec[i] != limVec[i]))
        |=> (cntVec[i] == $past(cntVec[i]) + CNT_W'(1))); // R1

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (!strobeVec[i].loadCount && (cntVec[i] == limVec[i]))
        |=> (cntVec[i] == '0)); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobeVec[i].loadCount |=> (cntVec[i] == $past(wrData))); // R5

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
      (hitVec[i] && enVec[i] && !strobeVec[i].writeCtrl) |=> pendVec[i]); // R4

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
      (!pendVec[i] && !hitVec[i]) |=> !pendVec[i]); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (pendVec[i] && !strobeVec[i].writeCtrl) |=> pendVec[i]); // R6

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strobeVec[i].writeCtrl && !hitVec[i]) |=> !irq[i]); // R6

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
      !strobeVec[i].loadLimit |=> (limVec[i] == $past(limVec[i]))); // R9
  end

endmodule

bind lcmp_timer lcmp_timer_chk #(
  .NUM_TIMERS(NUM_TIMERS),
  .CNT_W     (CNT_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrData   (wrData),
  .strobeVec(strobeVec),
  .cntVec   (cntVec),
  .limVec   (limVec),
  .hitVec   (hitVec),
  .enVec    (enVec),
  .pendVec  (pendVec),
  .irq      (irq)
);

// File: tb/lcmp_timer_tb_top.sv
`timescale 1ns/10ps
module lcmp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcmp_timer dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .rdData(rdData),
    .irq   (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Write: driven after a falling edge, taken on the rising edge, released at the next falling edge.
  task automatic wrReg(input int t, input int r, input logic [31:0] d);
    @(negedge clk);
    wrEn   = 1'b1;
    addr   = 3'(t * 4 + r);
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic rdReg(input int t, input int r, output logic [31:0] v);
    addr = 3'(t * 4 + r);
    #0.1;
    v = rdData;
  endtask

  function automatic logic [31:0] advance(input logic [31:0] c, input int k, input logic [31:0] lim);
    logic [31:0] v = c;
    for (int n = 0; n < k; n++) v = (v == lim) ? 32'd0 : v + 32'd1;
    return v;
  endfunction

  task automatic test_reset();
    logic [31:0] v;
    for (int t = 0; t < 2; t++) begin
      rdReg(t, 0, v); check("R2 count", v, 32'd0);
      rdReg(t, 1, v); check("R2 limit", v, 32'hFFFF_FFFF);
      rdReg(t, 2, v); check("R2 ctrl", v, 32'd0);
    end
    check("R2 irq", {30'd0, irq}, 32'd0);
  endtask

  task automatic test_count_load();
    logic [31:0] v, w;
    wrReg(0, 0, 32'd100);
    rdReg(0, 0, v); check("R5 count load", v, 32'd100);
    rdReg(0, 0, w); check("R8 read does not disturb", w, 32'd100);
    repeat (5) @(negedge clk);
    rdReg(0, 0, v); check("R1 increment", v, 32'd105);
  endtask

  task automatic test_wrap_irq();
    logic [31:0] v;
    wrReg(0, 2, 32'd1);
    wrReg(0, 1, 32'd10);
    wrReg(0, 0, 32'd7);
    rdReg(0, 0, v); check("R5 count load", v, 32'd7);
    repeat (3) @(negedge clk);
    rdReg(0, 0, v); check("R1 at limit", v, 32'd10);
    check("R4 no irq before limit", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    rdReg(0, 0, v); check("R3 wrap to zero", v, 32'd0);
    check("R7 irq level", {31'd0, irq[0]}, 32'd1);
    rdReg(0, 2, v); check("R4 pending bit", v, 32'd3);
  endtask

  task automatic test_one_shot();
    logic [31:0] v;
    repeat (11) @(negedge clk);
    rdReg(0, 0, v); check("R3 second wrap", v, 32'd0);
    check("R6 irq held", {31'd0, irq[0]}, 32'd1);
    wrReg(0, 2, 32'd1);
    rdReg(0, 0, v); check("R1 count across rearm", v, 32'd2);
    check("R6 rearm clears irq", {31'd0, irq[0]}, 32'd0);
    rdReg(0, 2, v); check("R6 ctrl after rearm", v, 32'd1);
    repeat (8) @(negedge clk);
    check("R6 no irq before next limit", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R6 periodic irq", {31'd0, irq[0]}, 32'd1);
  endtask

  task automatic test_coincide();
    logic [31:0] v;
    wrReg(0, 2, 32'd1);             // count 0 -> 2, pending cleared
    check("R6 cleared before collision", {31'd0, irq[0]}, 32'd0);
    repeat (7) @(negedge clk);      // count 9
    wrReg(0, 2, 32'd1);             // write lands while count == limit
    rdReg(0, 0, v); check("R3 wrap during rearm", v, 32'd0);
    check("R6 hit wins over rearm", {31'd0, irq[0]}, 32'd1);
    repeat (9) @(negedge clk);      // count 9
    wrReg(0, 0, 32'd5);             // count write lands on the wrap edge
    rdReg(0, 0, v); check("R5 load beats wrap", v, 32'd5);
  endtask

  task automatic test_disabled();
    logic [31:0] v;
    wrReg(0, 2, 32'd0);
    check("R7 irq off when disabled", {31'd0, irq[0]}, 32'd0);
    repeat (12) @(negedge clk);
    check("R4 no irq with enable clear", {31'd0, irq[0]}, 32'd0);
    rdReg(0, 2, v); check("R4 no pending with enable clear", v, 32'd0);
  endtask

  task automatic test_free_run();
    logic [31:0] v;
    wrReg(1, 0, 32'hFFFF_FFFD);
    rdReg(1, 0, v); check("R10 load near top", v, 32'hFFFF_FFFD);
    repeat (2) @(negedge clk);
    rdReg(1, 0, v); check("R10 top value", v, 32'hFFFF_FFFF);
    @(negedge clk);
    rdReg(1, 0, v); check("R10 rollover", v, 32'd0);
    @(negedge clk);
    rdReg(1, 0, v); check("R10 keeps running", v, 32'd1);
  endtask

  task automatic test_independent();
    logic [31:0] c0, v;
    rdReg(0, 0, c0);
    wrReg(1, 0, 32'd0);
    wrReg(1, 1, 32'd3);
    wrReg(1, 2, 32'd1);             // enable write lands while count1 == 3
    rdReg(1, 0, v); check("R3 channel 1 wrap", v, 32'd0);
    check("R9 only channel 1 irq", {30'd0, irq}, 32'd2);
    rdReg(0, 0, v); check("R9 channel 0 count", v, advance(c0, 6, 32'd10));
    rdReg(0, 1, v); check("R9 channel 0 limit", v, 32'd10);
    rdReg(0, 2, v); check("R9 channel 0 ctrl", v, 32'd0);
  endtask

  task automatic test_reserved();
    logic [31:0] c0, v;
    rdReg(0, 3, v); check("R8 reserved reads zero", v, 32'd0);
    rdReg(0, 0, c0);
    wrReg(0, 3, 32'hFFFF_FFFF);
    rdReg(0, 0, v); check("R8 reserved write, count", v, advance(c0, 2, 32'd10));
    rdReg(0, 1, v); check("R8 reserved write, limit", v, 32'd10);
    rdReg(0, 2, v); check("R8 reserved write, ctrl", v, 32'd0);
    check("R8 reserved write, irq0", {31'd0, irq[0]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_count_load();
    test_wrap_irq();
    test_one_shot();
    test_coincide();
    test_disabled();
    test_free_run();
    test_independent();
    test_reserved();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule